// File: doc/BRIEF.md
# Interrupt Event Notification Writer

This block converts a trigger from an interrupt source into exactly one 64-bit memory write aimed at a software-programmed notification address. A trigger is a single-cycle strobe carrying a source index. At the moment the strobe is accepted, the block reads two configuration words. The first is a notification port word: its lowest bit enables notification, and the same word with that bit cleared is the write address. The second is a table offset word: its upper 32 bits are the base of the global interrupt number range.

The block adds the source index to that base, giving a 64-bit global interrupt number. It sends this number as a big-endian doubleword on a valid/ready write-request master port. Triggers that arrive while earlier writes are still waiting for the fabric are queued in a small FIFO. When the FIFO is already full, a new trigger is dropped and a one-cycle overflow pulse is raised.

Top module: `notif_writer`

## Requirements
- R1: After synchronous reset, `wr_valid` and `ovf` are both 0.
- R2: A trigger that is accepted while the FIFO is empty raises `wr_valid` in the next cycle. `wr_addr` equals the notification port word, as sampled with the trigger, with bit 0 cleared.
- R3: When bit 0 of the notification port word is 0 at the trigger, no write request is produced and `ovf` stays 0.
- R4: The written number is bits 63:32 of the offset word, zero-extended to 64 bits, plus the source index. A carry into bit 32 is kept.
- R5: `wr_data` is that number in big-endian order: byte lane i (bits 8i+7:8i) holds byte 7-i of the number. Lane 0 therefore carries the most significant byte.
- R6: While `wr_valid` is 1 and `wr_ready` is 0, `wr_valid`, `wr_addr` and `wr_data` hold their values into the next cycle.
- R7: Up to DEPTH (default 4) accepted triggers are queued. Each one produces exactly one write, and the writes are issued in the order the triggers were accepted.
- R8: If an enabled, in-range trigger arrives while the FIFO holds DEPTH entries, that trigger is dropped and `ovf` is 1 for exactly the next cycle. This applies even if a write completes in the same cycle. The queued entries are not affected.
- R9: The port word and the offset word are captured when the trigger is accepted. Later changes to them do not alter a write that is already queued.
- R10: A trigger whose source index is NUM_SRC (default 14) or above is ignored: no write is produced and no overflow is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_valid | input | 1 | Single-cycle trigger strobe |
| trig_src | input | SRC_W (4) | Source index of the trigger |
| cfg_port | input | 64 | Notification port word: bit 0 enables notification, the rest is the address |
| cfg_offset | input | 64 | Offset word: bits 63:32 are the interrupt number base |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write request accepted by the fabric |
| wr_addr | output | 64 | Write address |
| wr_data | output | 64 | Big-endian global interrupt number |
| ovf | output | 1 | One-cycle pulse when a trigger was dropped |

## Verification
The hardest situation to reach is a trigger arriving against a full queue in the same cycle that the fabric finally accepts the oldest write. In that case the drop decision must still be based on the occupancy before the write completes. The bench holds `wr_ready` low and issues more triggers than the FIFO has places. It then releases `wr_ready` and triggers again in the same cycle. Random phases combine sparse ready, mixed enable bits and out-of-range indices, so that full, near-full and stalled conditions recur many times.

// File: rtl/notif_pkg.sv
package notif_pkg;

    localparam int WORD_W = 64;
    localparam int BASE_LSB = 32;

    typedef struct packed {
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] data;
    } notif_req_t;

    // Reorder bytes so that the most significant byte lands in lane 0.
    function automatic logic [WORD_W-1:0] to_big_endian(input logic [WORD_W-1:0] v);
        logic [WORD_W-1:0] r;
        for (int i = 0; i < WORD_W / 8; i++) begin
            r[8*i +: 8] = v[8*(WORD_W/8-1-i) +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/notif_former.sv
module notif_former
    import notif_pkg::*;
#(
    parameter int NUM_SRC = 14,
    parameter int SRC_W   = 4
) (
    input  logic              trig_valid,
    input  logic [SRC_W-1:0]  trig_src,
    input  logic [WORD_W-1:0] cfg_port,
    input  logic [WORD_W-1:0] cfg_offset,
    output logic              push,
    output notif_req_t        req
);
    localparam int BASE_W = WORD_W - BASE_LSB;

    logic              in_range;
    logic [WORD_W-1:0] number;

    always_comb begin
        in_range = ({1'b0, trig_src} < (SRC_W+1)'(NUM_SRC));
        push     = trig_valid && cfg_port[0] && in_range;
        number   = {{(WORD_W-BASE_W){1'b0}}, cfg_offset[WORD_W-1:BASE_LSB]}
                 + {{(WORD_W-SRC_W){1'b0}}, trig_src};
        req.addr = {cfg_port[WORD_W-1:1], 1'b0};
        req.data = to_big_endian(number);
    end

endmodule

// File: rtl/notif_fifo.sv
module notif_fifo
    import notif_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       push,
    input  notif_req_t din,
    input  logic       pop,
    output notif_req_t dout,
    output logic       empty,
    output logic       full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    notif_req_t       mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    always_comb begin
        empty   = (count == '0);
        full    = (count == CNT_W'(DEPTH));
        do_push = push && !full;
        do_pop  = pop && !empty;
        dout    = mem[rd_ptr];
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R7: occupancy never exceeds the storage
    assert_count_bound_R7: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    // R7: a pop with nothing pending does not change occupancy
    assert_no_underflow_R7: assert property (@(posedge clk) disable iff (rst)
        (empty && !push) |=> (count == '0));

endmodule

// File: rtl/notif_writer.sv
module notif_writer
    import notif_pkg::*;
#(
    parameter int NUM_SRC = 14,
    parameter int SRC_W   = 4,
    parameter int DEPTH   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig_valid,
    input  logic [SRC_W-1:0]  trig_src,
    input  logic [WORD_W-1:0] cfg_port,
    input  logic [WORD_W-1:0] cfg_offset,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [WORD_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic              ovf
);
    logic       fmt_push;
    notif_req_t fmt_req;
    notif_req_t head;
    logic       q_empty, q_full, q_pop;
    logic       ovf_q;

    notif_former #(
        .NUM_SRC (NUM_SRC),
        .SRC_W   (SRC_W)
    ) u_former (
        .trig_valid (trig_valid),
        .trig_src   (trig_src),
        .cfg_port   (cfg_port),
        .cfg_offset (cfg_offset),
        .push       (fmt_push),
        .req        (fmt_req)
    );

    notif_fifo #(
        .DEPTH (DEPTH)
    ) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (fmt_push),
        .din   (fmt_req),
        .pop   (q_pop),
        .dout  (head),
        .empty (q_empty),
        .full  (q_full)
    );

    always_comb begin
        wr_valid = !q_empty;
        wr_addr  = head.addr;
        wr_data  = head.data;
        q_pop    = wr_valid && wr_ready;
        ovf      = ovf_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_q <= 1'b0;
        end else begin
            ovf_q <= fmt_push && q_full;
        end
    end

    // R6: a stalled request keeps valid, address and data
    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    // R2: the issued address never carries the enable bit
    assert_addr_even_R2: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> (wr_addr[0] == 1'b0));

    // R3: a disabled trigger into an empty queue leaves it empty
    assert_disabled_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        (q_empty && trig_valid && !cfg_port[0]) |=> (!wr_valid && !ovf));

    // R8: an overflow pulse only follows a full queue
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        ovf |-> $past(q_full));

    // R8: the overflow pulse lasts one cycle unless another drop follows
    assert_ovf_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        (ovf && !(fmt_push && q_full)) |=> !ovf);

endmodule

// File: tb/notif_writer_bench.sv
module notif_writer_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        trig_valid;
    logic [3:0]  trig_src;
    logic [63:0] cfg_port;
    logic [63:0] cfg_offset;
    logic        wr_valid;
    logic        wr_ready;
    logic [63:0] wr_addr;
    logic [63:0] wr_data;
    logic        ovf;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [63:0] qa[$];
    logic [63:0] qd[$];
    logic        exp_ovf = 1'b0;
    logic        was_stall = 1'b0;
    logic [63:0] prev_a, prev_d;

    always #2 clk = ~clk;

    notif_writer u_notif_writer (
        .clk        (clk),
        .rst        (rst),
        .trig_valid (trig_valid),
        .trig_src   (trig_src),
        .cfg_port   (cfg_port),
        .cfg_offset (cfg_offset),
        .wr_valid   (wr_valid),
        .wr_ready   (wr_ready),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .ovf        (ovf)
    );

    function automatic logic [63:0] bswap(input logic [63:0] v);
        logic [63:0] r;
        for (int i = 0; i < 8; i++) r[8*i +: 8] = v[8*(7-i) +: 8];
        return r;
    endfunction

    function automatic logic [63:0] exp_number(input logic [63:0] off, input logic [3:0] s);
        return {32'd0, off[63:32]} + {60'd0, s};
    endfunction

    task automatic check(input logic ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic t, input logic [3:0] s, input logic [63:0] p,
                        input logic [63:0] o, input logic rdy);
        logic full_now, enab;
        @(negedge clk);
        trig_valid = t; trig_src = s; cfg_port = p; cfg_offset = o; wr_ready = rdy;
        #1;
        check(wr_valid === (qa.size() != 0), "R7 valid", {63'd0, wr_valid}, {63'd0, qa.size() != 0});
        check(ovf === exp_ovf, "R8 ovf", {63'd0, ovf}, {63'd0, exp_ovf});
        if (qa.size() != 0) begin
            check(wr_addr === qa[0], "R7 addr order", wr_addr, qa[0]);
            check(wr_data === qd[0], "R7 data order", wr_data, qd[0]);
        end
        if (was_stall) begin
            check(wr_addr === prev_a && wr_data === prev_d, "R6 hold", wr_data, prev_d);
        end
        was_stall = wr_valid && !rdy;
        prev_a = wr_addr; prev_d = wr_data;
        full_now = (qa.size() == 4);
        enab = t && p[0] && (s < 4'd14);
        if (wr_valid && rdy && qa.size() != 0) begin
            void'(qa.pop_front()); void'(qd.pop_front());
        end
        if (enab && !full_now) begin
            qa.push_back({p[63:1], 1'b0});
            qd.push_back(bswap(exp_number(o, s)));
        end
        exp_ovf = enab && full_now;
    endtask

    task automatic idle(input logic rdy);
        step(1'b0, 4'd0, 64'd0, 64'd0, rdy);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        rst = 1'b1; trig_valid = 1'b0; trig_src = '0;
        cfg_port = '0; cfg_offset = '0; wr_ready = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check(wr_valid === 1'b0, "R1 valid", {63'd0, wr_valid}, 64'd0);
        check(ovf === 1'b0, "R1 ovf", {63'd0, ovf}, 64'd0);
        @(negedge clk);
        rst = 1'b0;

        // R2/R4/R5 directed byte order
        step(1'b1, 4'd5, 64'h0000_00AB_CDEF_1001, {32'h1234_5678, 32'h9999_9999}, 1'b0);
        idle(1'b0);
        check(wr_addr === 64'h0000_00AB_CDEF_1000, "R2 addr", wr_addr, 64'h0000_00AB_CDEF_1000);
        check(wr_data === 64'h7D56_3412_0000_0000, "R5 bytes", wr_data, 64'h7D56_3412_0000_0000);
        idle(1'b1);
        idle(1'b1);

        // R4 carry into bit 32
        step(1'b1, 4'd13, 64'h0000_0000_0000_2001, {32'hFFFF_FFFF, 32'h0}, 1'b0);
        idle(1'b0);
        check(wr_data === 64'h0C00_0000_0100_0000, "R4 carry", wr_data, 64'h0C00_0000_0100_0000);
        idle(1'b1);
        idle(1'b1);

        // R3 disabled, R10 out of range
        step(1'b1, 4'd2, 64'h0000_0000_0000_3000, 64'h1_0000_0000, 1'b1);
        step(1'b1, 4'd14, 64'h0000_0000_0000_3001, 64'h1_0000_0000, 1'b1);
        step(1'b1, 4'd15, 64'h0000_0000_0000_3001, 64'h1_0000_0000, 1'b1);
        idle(1'b1);
        check(wr_valid === 1'b0 && ovf === 1'b0, "R3 R10 quiet", {63'd0, wr_valid}, 64'd0);

        // R8/R9: fill with ready low, change config, overflow with simultaneous pop
        for (int i = 0; i < 5; i++) begin
            step(1'b1, 4'(i), 64'h0000_0000_0000_4001 + 64'(i * 16), {32'(i * 100), 32'h0}, 1'b0);
        end
        idle(1'b0);
        check(ovf === 1'b1, "R8 drop", {63'd0, ovf}, 64'd1);
        step(1'b0, 4'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
        check(wr_addr === 64'h0000_0000_0000_4000, "R9 captured", wr_addr, 64'h0000_0000_0000_4000);
        step(1'b1, 4'd7, 64'h0000_0000_0000_5001, 64'h0, 1'b1);
        idle(1'b0);
        check(ovf === 1'b1, "R8 drop with pop", {63'd0, ovf}, 64'd1);
        repeat (6) idle(1'b1);

        // random phase
        for (int n = 0; n < 4000; n++) begin
            logic [63:0] p;
            p = {$urandom(), $urandom()};
            p[0] = ($urandom_range(0, 7) != 0);
            step($urandom_range(0, 2) != 0, 4'($urandom_range(0, 15)), p,
                 {$urandom(), $urandom()}, $urandom_range(0, 3) == 0);
        end
        repeat (8) idle(1'b1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule